// File: doc/BRIEF.md
# Control-register I2C slave

This block is the serial control port of a broadcast audio decoder. It watches the two-wire bus lines, sampled on the system clock, and answers one fixed device address. A write sets a small bank of 8-bit control registers whose contents drive the decoder's analog settings through parallel outputs. A read returns one status byte made from two carrier-detector inputs.

A write names a register slot in a subaddress byte and then carries any number of data bytes. The top bit of the subaddress byte picks how the slot moves between bytes: it either steps to the next slot, wrapping at the end of the bank, or stays on the same slot so that each byte overwrites the one before. A read has no subaddress phase: the status byte follows the address acknowledge straight away. The two top bits of slot 0 are also brought out on their own as the gain-curve select.

Top module: `mpx_ctl_i2c`

## Requirements
- R1: A start (SDA falling while SCL is high) begins a new address phase from any state, including in the middle of a transfer; a stop (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The block acknowledges address byte 0xB6 (write) and 0xB7 (read) by pulling SDA low during the ninth clock; any other address is not acknowledged and every following byte is ignored until the next start.
- R3: In the subaddress byte, bits 2:0 give the register slot, bit 7 gives the mode (0 step, 1 overwrite) and bits 6:3 are ignored.
- R4: In step mode, successive data bytes go to the named slot and then to each next slot, wrapping from slot 7 to slot 0.
- R5: In overwrite mode, every data byte of the transfer goes to the named slot, so the last byte stays.
- R6: Slots 0, 1, 2, 5 and 6 hold written data; writes to slots 3, 4 and 7 are acknowledged and dropped, and those slots read as zero on the register output.
- R7: A read sends the status byte MSB first with bit 1 = pilot detected, bit 0 = second-carrier detected and bits 7:2 = 0, sampled when the address acknowledge clock falls; a master acknowledge brings a fresh copy, a master non-acknowledge ends the read.
- R8: Reset clears every register and releases SDA.
- R9: The gain-curve output equals bits 7:6 of slot 0.
- R10: The subaddress byte and every data byte of a write are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| pilot_det_i | input | 1 | Pilot detector flag |
| aux_det_i | input | 1 | Second-carrier detector flag |
| regs_o | output | 64 | Register bank, slot n at bits 8n+7:8n |
| agc_curve_o | output | 2 | Gain-curve select from slot 0 bits 7:6 |

## Verification
The bench builds the block with its defaults: device address 0x5B, a three-bit slot index (eight slots) and a two-flop line sampler. Eight slots let a three-byte burst from slot 6 cross the wrap to slot 0 and let a burst from slot 3 pass both dropped slots before landing on slot 5. The default address makes 0xB4 a near miss that differs only in one address bit.

// File: rtl/mpx_ctl_pkg.sv
package mpx_ctl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } bus_st_e;

  // Status byte: pilot in bit 1, second carrier in bit 0.
  function automatic logic [7:0] status_byte(input logic pilot, input logic aux);
    return {6'b0, pilot, aux};
  endfunction

  // Address byte matches when its upper seven bits equal the device address.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // States in which the slave may hold SDA low.
  function automatic logic may_drive(input bus_st_e s);
    return (s == ST_ADDR_ACK) || (s == ST_SUB_ACK) ||
           (s == ST_WDATA_ACK) || (s == ST_RDATA);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign ev_rise  = scl_s & ~scl_p;
  assign ev_fall  = ~scl_s & scl_p;
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import mpx_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5B,
  parameter int         IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic             pilot_det,
  input  logic             aux_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  bus_st_e          st;
  logic [3:0]       cnt;
  logic [7:0]       shreg;
  logic [7:0]       tx;
  logic [IDX_W-1:0] idx;
  logic             renew, rd, mst_ack;
  logic [7:0]       stat_now;
  logic             byte_done;

  assign stat_now  = status_byte(pilot_det, aux_det);
  assign byte_done = (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      idx     <= '0;
      renew   <= 1'b0;
      rd      <= 1'b0;
      mst_ack <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (ev_stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (ev_rise) begin
        case (st)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end
          ST_RDATA: cnt <= cnt + 4'd1;
          ST_RACK:  mst_ack <= ~sda_s;
          default: ;
        endcase
      end else if (ev_fall) begin
        case (st)
          ST_ADDR: if (byte_done) begin
            if (addr_hit(shreg, DEV_ADDR)) begin
              st     <= ST_ADDR_ACK;
              sda_oe <= 1'b1;
              rd     <= shreg[0];
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_SUB: if (byte_done) begin
            st     <= ST_SUB_ACK;
            sda_oe <= 1'b1;
            idx    <= shreg[IDX_W-1:0];
            renew  <= shreg[7];
          end
          ST_WDATA: if (byte_done) begin
            st      <= ST_WDATA_ACK;
            sda_oe  <= 1'b1;
            wr_en   <= 1'b1;
            wr_idx  <= idx;
            wr_data <= shreg;
            if (!renew) idx <= idx + 1'b1;
          end
          ST_ADDR_ACK: begin
            cnt <= '0;
            if (rd) begin
              st     <= ST_RDATA;
              tx     <= stat_now;
              sda_oe <= ~stat_now[7];
            end else begin
              st     <= ST_SUB;
              sda_oe <= 1'b0;
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            st     <= ST_WDATA;
            cnt    <= '0;
            sda_oe <= 1'b0;
          end
          ST_RDATA: begin
            if (byte_done) begin
              st     <= ST_RACK;
              sda_oe <= 1'b0;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
          ST_RACK: begin
            if (mst_ack) begin
              st     <= ST_RDATA;
              cnt    <= '0;
              tx     <= stat_now;
              sda_oe <= ~stat_now[7];
            end else begin
              st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // SDA is pulled only in acknowledge slots or while sending status
  p_oe_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> may_drive(st));

  p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st == ST_ADDR) && !sda_oe);

  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (st == ST_IDLE) && !sda_oe);

  // SDA output only moves after an SCL fall or a bus condition
  p_sda_moves_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(ev_fall || ev_start || ev_stop));

  p_foreign_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && ev_fall && byte_done && !ev_start && !ev_stop &&
     shreg[7:1] != DEV_ADDR) |=> (st == ST_IDLE) && !sda_oe);

  p_write_from_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (st == ST_WDATA_ACK) && $past(st == ST_WDATA));

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
  parameter int                      IDX_W     = 3,
  parameter logic [(2**IDX_W)-1:0]   IMPL_MASK = 8'h67
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [7:0]                wr_data,
  output logic [(2**IDX_W)*8-1:0]   regs_o
);
  localparam int NREG = 2**IDX_W;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (IMPL_MASK[i]) begin : g_real
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  q <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))       q <= wr_data;
      end
      assign regs_o[i*8 +: 8] = q;
    end else begin : g_hole
      assign regs_o[i*8 +: 8] = 8'h00;
    end
  end

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && IMPL_MASK[wr_idx]) |=> regs_o[$past(wr_idx)*8 +: 8] == $past(wr_data));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(regs_o));

endmodule

// File: rtl/mpx_ctl_i2c.sv
module mpx_ctl_i2c #(
  parameter logic [6:0]              DEV_ADDR    = 7'h5B,
  parameter int                      IDX_W       = 3,
  parameter logic [(2**IDX_W)-1:0]   IMPL_MASK   = 8'h67,
  parameter int                      SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  input  logic                      pilot_det_i,
  input  logic                      aux_det_i,
  output logic [(2**IDX_W)*8-1:0]   regs_o,
  output logic [1:0]                agc_curve_o
);
  logic             sda_s, ev_start, ev_stop, ev_rise, ev_fall;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .pilot_det(pilot_det_i), .aux_det(aux_det_i),
    .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  ctl_regbank #(.IDX_W(IDX_W), .IMPL_MASK(IMPL_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs_o)
  );

  assign agc_curve_o = regs_o[7:6];

endmodule

// File: tb/mpx_ctl_i2c_bench.sv
module mpx_ctl_i2c_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic pilot = 1'b0, aux = 1'b0;
  logic sda_oe;
  logic [63:0] regs;
  logic [1:0]  agc;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0] model [8];

  always #4 clk = ~clk;

  mpx_ctl_i2c u_mpx_ctl_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pilot_det_i(pilot), .aux_det_i(aux),
    .regs_o(regs), .agc_curve_o(agc)
  );

  // {subaddress, byte count, d0, d1, d2}
  localparam logic [39:0] VEC [8] = '{
    {8'h00, 8'd3, 8'hA1, 8'hB2, 8'hC3},
    {8'h05, 8'd2, 8'h55, 8'h66, 8'h00},
    {8'h06, 8'd3, 8'h11, 8'h22, 8'h33},
    {8'h81, 8'd3, 8'h01, 8'h02, 8'h03},
    {8'h03, 8'd3, 8'h44, 8'h45, 8'h77},
    {8'hF2, 8'd2, 8'h9A, 8'hBC, 8'h00},
    {8'h84, 8'd1, 8'hEE, 8'h00, 8'h00},
    {8'h00, 8'd1, 8'h40, 8'h00, 8'h00}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] packed_model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic bit writable(input int i);
    return (i == 0) || (i == 1) || (i == 2) || (i == 5) || (i == 6);
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    acked = ~sda_line;
    wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl_m = 1'b0;
    end
    wt(Q); sda_m = ~give_ack; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_txn(input logic [7:0] addr, input logic [7:0] sub, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                           output int acks);
    bit a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    acks = 0;
    bus_start();
    send_byte(addr, a); acks += int'(a);
    send_byte(sub, a);  acks += int'(a);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a); acks += int'(a);
    end
    bus_stop();
  endtask

  task automatic model_write(input logic [7:0] sub, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    int ix;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    ix = int'(sub[2:0]);
    for (int k = 0; k < n; k++) begin
      if (writable(ix)) model[ix] = d[k];
      if (!sub[7]) ix = (ix + 1) % 8;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int acks;
    bit a;
    logic [7:0] rb, rb2;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    wt(5);
    // R8 reset state
    chk("R8 regs after reset", regs, 64'h0);
    chk("R8 sda released", {63'h0, sda_oe}, 64'h0);
    rst_n = 1'b1;
    wt(5);

    // Vector walk: R3 R4 R5 R6 R10
    for (int v = 0; v < 8; v++) begin
      write_txn(8'hB6, VEC[v][39:32], int'(VEC[v][31:24]),
                VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], acks);
      model_write(VEC[v][39:32], int'(VEC[v][31:24]),
                  VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
      chk("R10 all bytes acked", 64'(acks), 64'(int'(VEC[v][31:24]) + 2));
      chk("R4 R5 R6 R3 register bank", regs, packed_model());
      if (v == 7) chk("R9 gain curve", {62'h0, agc}, {62'h0, model[0][7:6]});
    end
    chk("R4 wrap reached slot 0 then overwritten", {56'h0, regs[7:0]}, 64'h40);
    chk("R6 dropped slots read zero", {40'h0, regs[63:56], regs[39:24]}, 64'h0);

    // R2 foreign address: no acks, nothing written
    write_txn(8'hB4, 8'h00, 1, 8'hFF, 8'h00, 8'h00, acks);
    chk("R2 foreign address not acked", 64'(acks), 64'h0);
    chk("R2 foreign write ignored", regs, packed_model());

    // R9 gain curve with top bits 11
    write_txn(8'hB6, 8'h80, 1, 8'hC5, 8'h00, 8'h00, acks);
    model[0] = 8'hC5;
    chk("R9 gain curve 11", {62'h0, agc}, 64'h3);

    // R1 repeated start mid transfer
    bus_start();
    send_byte(8'hB6, a);
    send_byte(8'h01, a);
    bus_start();
    send_byte(8'hB6, a);
    send_byte(8'h02, a);
    send_byte(8'h5A, a);
    bus_stop();
    model[2] = 8'h5A;
    chk("R1 repeated start restarts address phase", regs, packed_model());

    // R1 stop after subaddress: nothing written, SDA released
    bus_start();
    send_byte(8'hB6, a);
    send_byte(8'h05, a);
    bus_stop();
    wt(Q);
    chk("R1 stop releases SDA", {63'h0, sda_oe}, 64'h0);
    chk("R1 stop writes nothing", regs, packed_model());

    // R7 reads
    for (int c = 0; c < 4; c++) begin
      pilot = c[1]; aux = c[0];
      bus_start();
      send_byte(8'hB7, a);
      chk("R2 read address acked", {63'h0, a}, 64'h1);
      recv_byte(1'b0, rb);
      bus_stop();
      chk("R7 status byte", {56'h0, rb}, {62'h0, c[1], c[0]});
    end
    // R7 master ack brings a fresh copy
    pilot = 1'b1; aux = 1'b0;
    bus_start();
    send_byte(8'hB7, a);
    pilot = 1'b0; aux = 1'b1;
    recv_byte(1'b1, rb);
    recv_byte(1'b0, rb2);
    bus_stop();
    chk("R7 first byte sampled at address ack", {56'h0, rb}, 64'h02);
    chk("R7 second byte refreshed", {56'h0, rb2}, 64'h01);
    chk("R7 read leaves registers", regs, packed_model());

    // R8 reset mid run
    rst_n = 1'b0;
    wt(3);
    chk("R8 reset clears registers", regs, 64'h0);
    chk("R8 reset clears gain curve", {62'h0, agc}, 64'h0);
    rst_n = 1'b1;
    wt(5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule